// File: doc/BRIEF.md
# Fast Blank Video Source Switch

This block picks, one pixel at a time, between a composite-decoded video stream and an RGB/YUV stream. A fast-blank flag travels with the RGB/YUV stream and steers the choice. Before the flag steers anything, it passes through a programmable skew line and a persistence filter. The skew line moves the flag against the pixel data in steps of one clock (25 ns at the intended rate), in either direction. The filter asks for one or five consecutive active samples. The filtered flag is also driven out as a status pin.

Negative skew is possible because both video streams carry a fixed lead: they are held back by the largest negative step plus the one clock the filter adds. A single configuration word is written through a simple write strobe. It sets the skew, the filter length, the path mode, the soft-mix style and the data-format flag. A new word governs the block from the clock edge after the write, and the write clears the filter count.

Top module: `fbl_src_switch`

## Requirements
- R1: After reset `pix_out`, `fbl_active` and `fmt_rgb` are 0. The configuration is skew code 010, short filter, composite only, dynamic soft mix and RGB format (word 0x82 except the mode field, which is 10). The blend weight is 0.
- R2: A write with `cfg_we` high loads `cfg_wdata`. Bits [2:0] are the skew code, bit 3 picks the long filter, bits [5:4] are the path mode, bit 6 picks static soft mix and bit 7 marks the data as RGB (1) or YUV (0). The new word governs the output from the next clock edge onward.
- R3: In mode 01 the output pixel is the RGB/YUV input sampled three clock edges before the edge that registers it.
- R4: A skew code c (0 to 6) lines the flag up with data sampled (c − 2) clocks later, so code 000 is two clocks early, 010 is aligned and 110 is four clocks late. Code 111 behaves as 110.
- R5: With the short filter, `fbl_active` is high after each edge at which the aligned flag was high, and low after an edge at which it was low.
- R6: With the long filter, `fbl_active` goes high only after five consecutive edges with the aligned flag high. Any low sample restarts the count.
- R7: A configuration write clears the filter count, so `fbl_active` is low after the write edge.
- R8: In mode 01 only the RGB/YUV path reaches the output, whatever the flag does.
- R9: In modes 10 and 11 only the composite path reaches the output.
- R10: In mode 00 with static soft mix, the output is floor((composite + RGB)/2) while the filtered flag is high and the composite pixel otherwise.
- R11: In mode 00 with dynamic soft mix, a 3-bit weight w rises by one per clock, saturating at 7, while the filtered flag is high. It falls by one per clock, saturating at 0, while the flag is low. The output is the RGB pixel when w = 7 and floor((rgb·w + cv·(8 − w))/8) otherwise.
- R12: `fmt_rgb` repeats the format bit of the configuration that produced the same output pixel.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock |
| rst | input | 1 | Synchronous reset, active high |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_wdata | input | 8 | Configuration word |
| fbl_in | input | 1 | Fast-blank flag, active high |
| cv_pix | input | PIX_W | Composite-path pixel |
| rgb_pix | input | PIX_W | RGB/YUV-path pixel |
| pix_out | output | PIX_W | Selected or blended pixel |
| fbl_active | output | 1 | Filtered fast-blank status |
| fmt_rgb | output | 1 | Format flag matching `pix_out` |

## Verification
The bound checker watches four things on every clock. It checks the three-clock data latency in the forced RGB and forced composite modes, and that a configuration write always leaves the status low. It checks that the short filter follows a high flag when the skew code is zero, and that the blend weight never moves by more than one step per clock. Some behaviour only the bench scenarios can show, because it depends on a history of stimulus: the exact placement of a flag pulse for every skew code, the five-sample run of the long filter, the static 50/50 blend and the full ramp of the dynamic weight. The bench compares every output pixel and status bit against a model built from the requirements.

// File: rtl/fbl_sw_pkg.sv
package fbl_sw_pkg;

   typedef enum logic [1:0] {
      MIX_SOFT = 2'b00,
      MIX_RGB  = 2'b01,
      MIX_CVBS = 2'b10,
      MIX_RSVD = 2'b11
   } mix_e;

   // bit 7 rgb_sel, 6 static_mix, 5:4 mix, 3 long_qual, 2:0 skew
   typedef struct packed {
      logic       rgb_sel;
      logic       static_mix;
      mix_e       mix;
      logic       long_qual;
      logic [2:0] skew;
   } cfg_t;

   localparam cfg_t CFG_RESET = '{rgb_sel: 1'b1, static_mix: 1'b0, mix: MIX_CVBS,
                                  long_qual: 1'b0, skew: 3'b010};

   // reserved path mode falls back to composite only
   function automatic mix_e resolve_mix(input mix_e m);
      return (m == MIX_RSVD) ? MIX_CVBS : m;
   endfunction

endpackage

// File: rtl/fbl_align.sv
module fbl_align #(
   parameter int DEPTH  = 6,
   parameter int CODE_W = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic              fbl_in,
   input  logic [CODE_W-1:0] code,
   output logic              fbl_aligned
);
   localparam logic [CODE_W-1:0] TOP_CODE = CODE_W'(DEPTH);

   logic [DEPTH:1]    sr;
   logic [DEPTH:0]    taps;
   logic [CODE_W-1:0] eff;

   always_ff @(posedge clk) begin
      if (rst) sr <= '0;
      else     sr <= {sr[DEPTH-1:1], fbl_in};
   end

   assign taps        = {sr, fbl_in};
   assign eff         = (code > TOP_CODE) ? TOP_CODE : code;
   assign fbl_aligned = taps[eff];

endmodule

// File: rtl/fbl_qualifier.sv
module fbl_qualifier #(
   parameter int SHORT_RUN = 1,
   parameter int LONG_RUN  = 5
) (
   input  logic clk,
   input  logic rst,
   input  logic clear,
   input  logic fbl,
   input  logic long_sel,
   output logic active
);
   localparam int CNT_W = $clog2(LONG_RUN + 1);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(LONG_RUN);
   localparam logic [CNT_W-1:0] CNT_SHT = CNT_W'(SHORT_RUN);

   logic [CNT_W-1:0] run_q;

   always_ff @(posedge clk) begin
      if (rst || clear) run_q <= '0;
      else if (!fbl)    run_q <= '0;
      else if (run_q != CNT_MAX) run_q <= run_q + 1'b1;
   end

   assign active = run_q >= (long_sel ? CNT_MAX : CNT_SHT);

endmodule

// File: rtl/fbl_mix_blend.sv
module fbl_mix_blend
   import fbl_sw_pkg::*;
#(
   parameter int PIX_W  = 8,
   parameter int W_BITS = 3
) (
   input  logic              clk,
   input  logic              rst,
   input  logic [PIX_W-1:0]  cv,
   input  logic [PIX_W-1:0]  rgb,
   input  mix_e              mode,
   input  logic              static_mix,
   input  logic              active,
   input  logic              rgb_sel,
   output logic [PIX_W-1:0]  pix_out,
   output logic              fmt_rgb,
   output logic [W_BITS-1:0] weight
);
   localparam int SUM_W = PIX_W + W_BITS + 1;
   localparam int SCALE = 1 << W_BITS;
   localparam logic [W_BITS-1:0] W_MAX = '1;

   logic [W_BITS-1:0] w_next;
   logic [SUM_W-1:0]  acc, half;
   logic [PIX_W-1:0]  nxt;

   always_comb begin
      if (active) w_next = (weight == W_MAX) ? weight : weight + 1'b1;
      else        w_next = (weight == '0)    ? weight : weight - 1'b1;
   end

   always_comb begin
      acc  = SUM_W'(rgb) * SUM_W'(weight) + SUM_W'(cv) * (SUM_W'(SCALE) - SUM_W'(weight));
      half = (SUM_W'(cv) + SUM_W'(rgb)) >> 1;
      unique case (resolve_mix(mode))
         MIX_RGB:  nxt = rgb;
         MIX_SOFT: begin
            if (static_mix)            nxt = active ? PIX_W'(half) : cv;
            else if (weight == W_MAX)  nxt = rgb;
            else                       nxt = PIX_W'(acc >> W_BITS);
         end
         default:  nxt = cv;
      endcase
   end

   always_ff @(posedge clk) begin
      if (rst) begin
         weight  <= '0;
         pix_out <= '0;
         fmt_rgb <= 1'b0;
      end else begin
         weight  <= w_next;
         pix_out <= nxt;
         fmt_rgb <= rgb_sel;
      end
   end

endmodule

// File: rtl/fbl_src_switch.sv
module fbl_src_switch
   import fbl_sw_pkg::*;
#(
   parameter int PIX_W     = 8,
   parameter int MAX_LEAD  = 2,
   parameter int MAX_LAG   = 4,
   parameter int SHORT_RUN = 1,
   parameter int LONG_RUN  = 5,
   parameter int W_BITS    = 3
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             cfg_we,
   input  logic [7:0]       cfg_wdata,
   input  logic             fbl_in,
   input  logic [PIX_W-1:0] cv_pix,
   input  logic [PIX_W-1:0] rgb_pix,
   output logic [PIX_W-1:0] pix_out,
   output logic             fbl_active,
   output logic             fmt_rgb
);
   localparam int DEPTH    = MAX_LEAD + MAX_LAG;
   localparam int DATA_LAT = MAX_LEAD + 1;

   generate
      if (DEPTH < 2 || DEPTH > 7) begin : g_bad_depth
         $error("skew depth must lie in 2..7");
      end
      if (SHORT_RUN < 1 || LONG_RUN < SHORT_RUN) begin : g_bad_run
         $error("filter run lengths inconsistent");
      end
      if (PIX_W < 2 || W_BITS < 1) begin : g_bad_width
         $error("pixel or weight width too small");
      end
   endgenerate

   cfg_t              cfg_q;
   logic              fbl_al;
   logic [W_BITS-1:0] blend_w;
   logic [PIX_W-1:0]  cv_pipe  [DATA_LAT];
   logic [PIX_W-1:0]  rgb_pipe [DATA_LAT];

   always_ff @(posedge clk) begin
      if (rst)         cfg_q <= CFG_RESET;
      else if (cfg_we) cfg_q <= cfg_t'(cfg_wdata);
   end

   genvar s;
   generate
      for (s = 0; s < DATA_LAT; s++) begin : g_lead
         always_ff @(posedge clk) begin
            if (rst) begin
               cv_pipe[s]  <= '0;
               rgb_pipe[s] <= '0;
            end else if (s == 0) begin
               cv_pipe[s]  <= cv_pix;
               rgb_pipe[s] <= rgb_pix;
            end else begin
               cv_pipe[s]  <= cv_pipe[(s == 0) ? 0 : s-1];
               rgb_pipe[s] <= rgb_pipe[(s == 0) ? 0 : s-1];
            end
         end
      end
   endgenerate

   fbl_align #(.DEPTH(DEPTH), .CODE_W(3)) align_i (
      .clk(clk), .rst(rst), .fbl_in(fbl_in), .code(cfg_q.skew), .fbl_aligned(fbl_al)
   );

   fbl_qualifier #(.SHORT_RUN(SHORT_RUN), .LONG_RUN(LONG_RUN)) qual_i (
      .clk(clk), .rst(rst), .clear(cfg_we), .fbl(fbl_al),
      .long_sel(cfg_q.long_qual), .active(fbl_active)
   );

   fbl_mix_blend #(.PIX_W(PIX_W), .W_BITS(W_BITS)) mix_i (
      .clk(clk), .rst(rst),
      .cv(cv_pipe[DATA_LAT-1]), .rgb(rgb_pipe[DATA_LAT-1]),
      .mode(cfg_q.mix), .static_mix(cfg_q.static_mix), .active(fbl_active),
      .rgb_sel(cfg_q.rgb_sel), .pix_out(pix_out), .fmt_rgb(fmt_rgb), .weight(blend_w)
   );

endmodule

// File: rtl/fbl_src_switch_chk.sv
module fbl_src_switch_chk
   import fbl_sw_pkg::*;
#(
   parameter int PIX_W  = 8,
   parameter int W_BITS = 3
) (
   input logic              clk,
   input logic              rst,
   input logic              cfg_we,
   input logic              fbl_in,
   input logic [PIX_W-1:0]  cv_pix,
   input logic [PIX_W-1:0]  rgb_pix,
   input logic [PIX_W-1:0]  pix_out,
   input logic              fbl_active,
   input cfg_t              cfg_q,
   input logic [W_BITS-1:0] weight
);
   logic [2:0] age_q;

   always_ff @(posedge clk) begin
      if (rst)             age_q <= '0;
      else if (age_q != 7) age_q <= age_q + 1'b1;
   end

   p_rgb_latency_r3: assert property (@(posedge clk) disable iff (rst)
      (age_q >= 4 && cfg_q.mix == MIX_RGB) |=> (pix_out == $past(rgb_pix, 4)));

   p_cvbs_latency_r9: assert property (@(posedge clk) disable iff (rst)
      (age_q >= 4 && (cfg_q.mix == MIX_CVBS || cfg_q.mix == MIX_RSVD))
      |=> (pix_out == $past(cv_pix, 4)));

   p_short_follow_r5: assert property (@(posedge clk) disable iff (rst)
      (cfg_q.skew == 3'd0 && !cfg_q.long_qual && !cfg_we && fbl_in) |=> fbl_active);

   p_write_clears_r7: assert property (@(posedge clk) disable iff (rst)
      cfg_we |=> !fbl_active);

   p_weight_step_r11: assert property (@(posedge clk) disable iff (rst)
      (weight != $past(weight)) |->
      ({1'b0, weight} == {1'b0, $past(weight)} + 1'b1 ||
       {1'b0, weight} + 1'b1 == {1'b0, $past(weight)}));

endmodule

bind fbl_src_switch fbl_src_switch_chk #(.PIX_W(PIX_W), .W_BITS(W_BITS)) chk_i (
   .clk(clk), .rst(rst), .cfg_we(cfg_we), .fbl_in(fbl_in), .cv_pix(cv_pix),
   .rgb_pix(rgb_pix), .pix_out(pix_out), .fbl_active(fbl_active),
   .cfg_q(cfg_q), .weight(blend_w)
);

// File: tb/fbl_src_switch_tb_top.sv
module fbl_src_switch_tb_top;
   logic       clk = 1'b0;
   logic       rst = 1'b1;
   logic       cfg_we = 1'b0;
   logic [7:0] cfg_wdata = '0;
   logic       fbl_in = 1'b0;
   logic [7:0] cv_pix = '0, rgb_pix = '0;
   logic [7:0] pix_out;
   logic       fbl_active, fmt_rgb;

   int  n_vec = 0, n_bad = 0;
   bit  done = 0;

   // scoreboard queues
   logic [7:0] pix_q [$];
   logic       act_q [$];
   logic       fmt_q [$];
   string      tag_q [$];

   // reference state built from the requirements
   logic       fh [8];
   logic [7:0] ch [4], rh [4];
   int         m_cnt, m_w;
   logic       m_act;
   logic [7:0] m_cfg;

   always #10 clk = ~clk;

   fbl_src_switch dut_i (
      .clk(clk), .rst(rst), .cfg_we(cfg_we), .cfg_wdata(cfg_wdata), .fbl_in(fbl_in),
      .cv_pix(cv_pix), .rgb_pix(rgb_pix), .pix_out(pix_out),
      .fbl_active(fbl_active), .fmt_rgb(fmt_rgb)
   );

   task automatic step(input logic we, input logic [7:0] wd, input logic [7:0] cv,
                       input logic [7:0] rg, input logic fb, input string tag);
      int d, e;
      logic al;
      @(posedge clk);
      #5;
      cfg_we = we; cfg_wdata = wd; cv_pix = cv; rgb_pix = rg; fbl_in = fb;
      for (int j = 7; j > 0; j--) fh[j] = fh[j-1];
      fh[0] = fb;
      for (int j = 3; j > 0; j--) begin ch[j] = ch[j-1]; rh[j] = rh[j-1]; end
      ch[0] = cv; rh[0] = rg;
      d  = (m_cfg[2:0] == 3'd7) ? 6 : int'(m_cfg[2:0]);
      al = fh[d];
      case (m_cfg[5:4])
         2'b01: e = rh[3];
         2'b00: begin
            if (m_cfg[6])       e = m_act ? (int'(ch[3]) + int'(rh[3])) / 2 : ch[3];
            else if (m_w == 7)  e = rh[3];
            else                e = (int'(rh[3]) * m_w + int'(ch[3]) * (8 - m_w)) / 8;
         end
         default: e = ch[3];
      endcase
      pix_q.push_back(8'(e));
      fmt_q.push_back(m_cfg[7]);
      tag_q.push_back(tag);
      m_w   = m_act ? ((m_w == 7) ? 7 : m_w + 1) : ((m_w == 0) ? 0 : m_w - 1);
      m_cnt = we ? 0 : (al ? ((m_cnt == 5) ? 5 : m_cnt + 1) : 0);
      if (we) m_cfg = wd;
      m_act = m_cnt >= (m_cfg[3] ? 5 : 1);
      act_q.push_back(m_act);
   endtask

   task automatic idle(input int n, input logic [7:0] cv, input logic [7:0] rg,
                       input logic fb, input string tag);
      for (int i = 0; i < n; i++) step(1'b0, 8'h00, cv + 8'(i * 7), rg - 8'(i * 5), fb, tag);
   endtask

   task automatic wr(input logic [7:0] wd, input string tag);
      step(1'b1, wd, 8'd11, 8'd222, 1'b0, tag);
   endtask

   // monitor: compares what the last edge produced
   always begin
      @(posedge clk);
      #2;
      if (pix_q.size() > 0) begin
         logic [7:0] ep;
         logic       ea, ef;
         string      t;
         ep = pix_q.pop_front(); ea = act_q.pop_front();
         ef = fmt_q.pop_front(); t  = tag_q.pop_front();
         n_vec++;
         if (pix_out !== ep || fbl_active !== ea || fmt_rgb !== ef) begin
            n_bad++;
            $display("FAIL %s: pix=%0d act=%0b fmt=%0b, expected pix=%0d act=%0b fmt=%0b",
                     t, pix_out, fbl_active, fmt_rgb, ep, ea, ef);
         end
      end
   end

   initial begin
      #4000000;
      if (!done) begin
         n_bad++;
         $display("FAIL watchdog: run did not complete, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
         $finish;
      end
   end

   initial begin
      for (int j = 0; j < 8; j++) fh[j] = 1'b0;
      for (int j = 0; j < 4; j++) begin ch[j] = '0; rh[j] = '0; end
      m_cnt = 0; m_w = 0; m_act = 1'b0; m_cfg = 8'hA2;
      repeat (3) @(posedge clk);
      #2;
      n_vec++;
      if (pix_out !== 8'd0 || fbl_active !== 1'b0 || fmt_rgb !== 1'b0) begin
         n_bad++;
         $display("FAIL R1: pix=%0d act=%0b fmt=%0b, expected pix=0 act=0 fmt=0",
                  pix_out, fbl_active, fmt_rgb);
      end
      #3 rst = 1'b0;

      // R1 R9 R12: default word, composite only, flag toggling
      for (int i = 0; i < 8; i++) step(1'b0, 8'h00, 8'(i * 17 + 3), 8'(255 - i * 9), i[0], "R9");
      // R2 R3 R8: forced RGB path
      wr(8'h92, "R2");
      for (int i = 0; i < 10; i++) step(1'b0, 8'h00, 8'(i * 3), 8'(i * 23 + 1), i[1], "R8");
      idle(4, 8'd50, 8'd90, 1'b1, "R3");
      // R4: single flag pulse for every skew code
      for (int c = 0; c < 8; c++) begin
         wr(8'h90 | 8'(c), "R4");
         idle(2, 8'd5, 8'd6, 1'b0, "R4");
         step(1'b0, 8'h00, 8'd7, 8'd8, 1'b1, "R4");
         idle(9, 8'd9, 8'd10, 1'b0, "R4");
      end
      // R5: short filter, zero skew code
      wr(8'h90, "R5");
      idle(1, 8'd1, 8'd2, 1'b1, "R5");
      idle(1, 8'd1, 8'd2, 1'b0, "R5");
      idle(2, 8'd1, 8'd2, 1'b1, "R5");
      idle(3, 8'd1, 8'd2, 1'b0, "R5");
      // R6: long filter, broken and full runs
      wr(8'h9A, "R6");
      idle(4, 8'd3, 8'd4, 1'b1, "R6");
      idle(1, 8'd3, 8'd4, 1'b0, "R6");
      idle(7, 8'd3, 8'd4, 1'b1, "R6");
      idle(4, 8'd3, 8'd4, 1'b0, "R6");
      // R7: rewrite while the flag is held high
      idle(8, 8'd3, 8'd4, 1'b1, "R7");
      step(1'b1, 8'h9A, 8'd3, 8'd4, 1'b1, "R7");
      idle(7, 8'd3, 8'd4, 1'b1, "R7");
      // R10: static soft mix
      wr(8'hC2, "R10");
      idle(6, 8'd21, 8'd200, 1'b1, "R10");
      idle(6, 8'd99, 8'd30, 1'b0, "R10");
      // R11: dynamic ramp up and down
      wr(8'h82, "R11");
      idle(14, 8'd40, 8'd200, 1'b1, "R11");
      idle(14, 8'd40, 8'd200, 1'b0, "R11");
      // R9: reserved mode acts as composite only
      wr(8'hB2, "R9");
      idle(8, 8'd60, 8'd180, 1'b1, "R9");
      // R12: YUV format flag
      wr(8'h12, "R12");
      idle(6, 8'd70, 8'd140, 1'b0, "R12");

      repeat (3) @(posedge clk);
      #5;
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
   end

endmodule